// File: doc/BRIEF.md
# Aligned Power-of-Two Region Splitter

This block covers one address region with a run of naturally aligned power-of-two translation windows. It takes a request with a physical start, a bus start, a size, an action word and the index of the first free window. It then writes one window configuration per clock into an external window register bank. Each configuration carries an index, an enable bit, a match address, a remap address, a mask and the action word. After every window the two starts move up by the window size, the size left shrinks by the same amount, and the index advances. The request ends with a one-cycle done pulse. That pulse carries a status code and the next free index.

A second request kind, close-out, is issued once every region has been mapped. It writes all-zero configurations to each window from a given index up to the last one. A failed region leaves an internal error flag set. Until the next close-out, later map requests are skipped. The close-out then clears every window from index 0, reports the failure, and clears the flag.

The controller is a four-state machine. IDLE accepts a request: a map request goes to STEP, or to DONE when the error flag is set; a close-out goes to CLEAR. STEP stays while it emits windows and falls to DONE when the size is used up, the windows run out, or a window is rejected. CLEAR stays while it emits cleared windows and falls to DONE past the last index. DONE lasts one cycle and returns to IDLE.

Top module: `region_splitter`

## Requirements
- R1: While reset is held and after release, req_ready is 1, wr_valid is 0 and done is 0.
- R2: The size of each window is the largest power of two that does not exceed the size left. When the physical start is nonzero, the size is further limited to the value of the lowest set bit of that start. An emitted window has wr_enable=1, wr_match equal to the physical start, wr_remap equal to the bus start, wr_mask equal to the bitwise inverse of (size-1), and wr_action equal to the request's action.
- R3: After each accepted window write, the physical start and the bus start each grow by the window size, the size left shrinks by it, and the next write uses the next higher index.
- R4: A window smaller than 0x10000 bytes, or a bus start with any bit set below the window size, ends the request with status 1 (invalid). No write is made for that window.
- R5: A nonzero size left when the index reaches the window count (8) gives status 1. A region whose last window lands exactly on index 7 gives status 0 (ok).
- R6: A map request with size 0 gives status 0, makes no writes, and reports done_next equal to req_win.
- R7: After any status-1 result, each map request gives status 2 (skipped) with no writes, until a close-out completes.
- R8: A close-out (req_op=1) writes wr_enable=0 and all-zero fields, in ascending index order, from req_win up to 7. If the error flag is set, it starts at index 0 instead and reports status 1; otherwise it reports status 0. Either way the flag is then cleared.
- R9: A write is offered while wr_valid=1 and completes when wr_ready=1. The payload holds still while it waits. With wr_ready held high, a request with N writes raises done on the (N+2)th cycle after acceptance, and a skipped request raises done on the first cycle.
- R10: done is high for exactly one cycle and carries done_status and done_next, the index after the last write. req_ready is 0 from acceptance until after done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle and taking a request |
| req_op | input | 1 | 0 map region, 1 close-out |
| req_phys | input | ADDR_W | Physical start of region |
| req_bus | input | ADDR_W | Bus start of region |
| req_size | input | ADDR_W | Region size in bytes |
| req_action | input | ACT_W | Action word copied into each window |
| req_win | input | IW | First free window index |
| wr_valid | output | 1 | Window write offered |
| wr_ready | input | 1 | Window bank takes the write |
| wr_idx | output | WIW | Window index |
| wr_enable | output | 1 | Window enable (0 on close-out) |
| wr_match | output | ADDR_W | Match address |
| wr_remap | output | ADDR_W | Remap address |
| wr_mask | output | ADDR_W | Address mask |
| wr_action | output | ACT_W | Action word |
| done | output | 1 | One-cycle completion pulse |
| done_status | output | 2 | 0 ok, 1 invalid, 2 skipped |
| done_next | output | IW | Next free window index |

## Verification
Two of the block's exit conditions can meet in one step. These are the size running out and the window index running out. A region sized so that its final window falls on index 7 provokes this. It is judged correct when the status is ok and not invalid. A companion region, one window larger, must report invalid after writing indices 6 and 7. A second overlap occurs when a close-out follows a failure: the clear sequence must start from index 0 and ignore the requested index, and the error report and the flag release must both happen in the same done pulse. The next map request shows that the flag has been released.

// File: rtl/rs_pkg.sv
package rs_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_STEP  = 2'd1,
        ST_CLEAR = 2'd2,
        ST_DONE  = 2'd3
    } rs_state_e;

    typedef enum logic [1:0] {
        RS_OK      = 2'd0,
        RS_INVALID = 2'd1,
        RS_SKIPPED = 2'd2
    } rs_status_e;

    localparam logic OP_MAP   = 1'b0;
    localparam logic OP_CLOSE = 1'b1;
endpackage

// File: rtl/rs_win_calc.sv
module rs_win_calc #(
    parameter int AW       = 40,
    parameter int MIN_LOG2 = 16
) (
    input  logic [AW-1:0] cur_phys,
    input  logic [AW-1:0] cur_bus,
    input  logic [AW-1:0] cur_rem,
    output logic [AW-1:0] win_size,
    output logic [AW-1:0] win_mask,
    output logic          win_ok
);
    localparam logic [AW-1:0] ONE     = {{(AW-1){1'b0}}, 1'b1};
    localparam logic [AW-1:0] MIN_WIN = ONE << MIN_LOG2;

    logic [AW-1:0] fit_p2;
    logic [AW-1:0] low_bit;

    // Highest set bit of the remaining size.
    always_comb begin
        fit_p2 = '0;
        for (int i = 0; i < AW; i++) begin
            if (cur_rem[i]) begin
                fit_p2 = ONE << i;
            end
        end
    end

    // Natural alignment of the physical start.
    assign low_bit = cur_phys & (~cur_phys + ONE);

    always_comb begin
        if ((cur_phys != '0) && (low_bit < fit_p2)) begin
            win_size = low_bit;
        end else begin
            win_size = fit_p2;
        end
        win_mask = ~(win_size - ONE);
        win_ok   = (win_size >= MIN_WIN) && ((cur_bus & ~win_mask) == '0);
    end
endmodule

// File: rtl/rs_ctrl.sv
module rs_ctrl
    import rs_pkg::*;
#(
    parameter int AW       = 40,
    parameter int ACT_W    = 32,
    parameter int NWIN     = 8,
    parameter int MIN_LOG2 = 16,
    parameter int IW       = 4,
    parameter int WIW      = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic             req_op,
    input  logic [AW-1:0]    req_phys,
    input  logic [AW-1:0]    req_bus,
    input  logic [AW-1:0]    req_size,
    input  logic [ACT_W-1:0] req_action,
    input  logic [IW-1:0]    req_win,
    output logic [AW-1:0]    cur_phys,
    output logic [AW-1:0]    cur_bus,
    output logic [AW-1:0]    cur_rem,
    input  logic [AW-1:0]    win_size,
    input  logic [AW-1:0]    win_mask,
    input  logic             win_ok,
    output logic             wr_valid,
    input  logic             wr_ready,
    output logic [WIW-1:0]   wr_idx,
    output logic             wr_enable,
    output logic [AW-1:0]    wr_match,
    output logic [AW-1:0]    wr_remap,
    output logic [AW-1:0]    wr_mask,
    output logic [ACT_W-1:0] wr_action,
    output logic             done,
    output logic [1:0]       done_status,
    output logic [IW-1:0]    done_next
);
    localparam logic [IW-1:0] WIN_END = IW'(NWIN);
    localparam logic [IW-1:0] IDX_ONE = {{(IW-1){1'b0}}, 1'b1};

    rs_state_e  state_q, state_d;
    rs_status_e status_q, status_d;

    logic             op_q;
    logic [AW-1:0]    phys_q, bus_q, rem_q;
    logic [ACT_W-1:0] act_q;
    logic [IW-1:0]    idx_q;
    logic             sticky_q;

    logic idx_free;
    logic step_emit;
    logic clr_emit;

    assign idx_free  = (idx_q < WIN_END);
    assign step_emit = (state_q == ST_STEP) && (rem_q != '0) && idx_free && win_ok;
    assign clr_emit  = (state_q == ST_CLEAR) && idx_free;

    assign cur_phys = phys_q;
    assign cur_bus  = bus_q;
    assign cur_rem  = rem_q;

    // Next-state decision
    always_comb begin
        state_d  = state_q;
        status_d = status_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    if (req_op == OP_CLOSE) begin
                        state_d = ST_CLEAR;
                    end else if (sticky_q) begin
                        state_d  = ST_DONE;
                        status_d = RS_SKIPPED;
                    end else begin
                        state_d = ST_STEP;
                    end
                end
            end
            ST_STEP: begin
                if (!step_emit) begin
                    state_d  = ST_DONE;
                    status_d = (rem_q == '0) ? RS_OK : RS_INVALID;
                end
            end
            ST_CLEAR: begin
                if (!clr_emit) begin
                    state_d  = ST_DONE;
                    status_d = sticky_q ? RS_INVALID : RS_OK;
                end
            end
            ST_DONE: begin
                state_d = ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            status_q <= RS_OK;
        end else begin
            state_q  <= state_d;
            status_q <= status_d;
        end
    end

    // Working registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q     <= OP_MAP;
            phys_q   <= '0;
            bus_q    <= '0;
            rem_q    <= '0;
            act_q    <= '0;
            idx_q    <= '0;
            sticky_q <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        op_q   <= req_op;
                        phys_q <= req_phys;
                        bus_q  <= req_bus;
                        rem_q  <= req_size;
                        act_q  <= req_action;
                        idx_q  <= ((req_op == OP_CLOSE) && sticky_q) ? '0 : req_win;
                    end
                end
                ST_STEP: begin
                    if (step_emit && wr_ready) begin
                        phys_q <= phys_q + win_size;
                        bus_q  <= bus_q + win_size;
                        rem_q  <= rem_q - win_size;
                        idx_q  <= idx_q + IDX_ONE;
                    end else if (!step_emit && (rem_q != '0)) begin
                        sticky_q <= 1'b1;
                    end
                end
                ST_CLEAR: begin
                    if (clr_emit && wr_ready) begin
                        idx_q <= idx_q + IDX_ONE;
                    end
                end
                ST_DONE: begin
                    if (op_q == OP_CLOSE) begin
                        sticky_q <= 1'b0;
                    end
                end
                default: begin
                    sticky_q <= sticky_q;
                end
            endcase
        end
    end

    // Outputs
    always_comb begin
        req_ready   = (state_q == ST_IDLE);
        wr_valid    = step_emit || clr_emit;
        wr_enable   = step_emit;
        wr_idx      = idx_q[WIW-1:0];
        wr_match    = step_emit ? phys_q   : '0;
        wr_remap    = step_emit ? bus_q    : '0;
        wr_mask     = step_emit ? win_mask : '0;
        wr_action   = step_emit ? act_q    : '0;
        done        = (state_q == ST_DONE);
        done_status = status_q;
        done_next   = idx_q;
    end

    // R9
    wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_idx) && $stable(wr_match)
            && $stable(wr_remap) && $stable(wr_mask) && $stable(wr_action)));

    // R4
    min_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_enable) |-> (wr_mask[MIN_LOG2-1:0] == '0));

    // R2
    align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_enable) |-> (((wr_remap & ~wr_mask) == '0)
            && ((wr_match & ~wr_mask) == '0)));

    // R3
    idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_ready) |=> (!wr_valid || (wr_idx == $past(wr_idx) + 1'b1)));

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

// File: rtl/region_splitter.sv
module region_splitter #(
    parameter int ADDR_W       = 40,
    parameter int ACT_W        = 32,
    parameter int NUM_WIN      = 8,
    parameter int MIN_WIN_LOG2 = 16,
    localparam int IW          = $clog2(NUM_WIN + 1),
    localparam int WIW         = $clog2(NUM_WIN)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_op,
    input  logic [ADDR_W-1:0] req_phys,
    input  logic [ADDR_W-1:0] req_bus,
    input  logic [ADDR_W-1:0] req_size,
    input  logic [ACT_W-1:0]  req_action,
    input  logic [IW-1:0]     req_win,
    output logic              wr_valid,
    input  logic              wr_ready,
    output logic [WIW-1:0]    wr_idx,
    output logic              wr_enable,
    output logic [ADDR_W-1:0] wr_match,
    output logic [ADDR_W-1:0] wr_remap,
    output logic [ADDR_W-1:0] wr_mask,
    output logic [ACT_W-1:0]  wr_action,
    output logic              done,
    output logic [1:0]        done_status,
    output logic [IW-1:0]     done_next
);
    logic [ADDR_W-1:0] cur_phys, cur_bus, cur_rem;
    logic [ADDR_W-1:0] win_size, win_mask;
    logic              win_ok;

    rs_win_calc #(
        .AW       (ADDR_W),
        .MIN_LOG2 (MIN_WIN_LOG2)
    ) u_calc (
        .cur_phys (cur_phys),
        .cur_bus  (cur_bus),
        .cur_rem  (cur_rem),
        .win_size (win_size),
        .win_mask (win_mask),
        .win_ok   (win_ok)
    );

    rs_ctrl #(
        .AW       (ADDR_W),
        .ACT_W    (ACT_W),
        .NWIN     (NUM_WIN),
        .MIN_LOG2 (MIN_WIN_LOG2),
        .IW       (IW),
        .WIW      (WIW)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_ready   (req_ready),
        .req_op      (req_op),
        .req_phys    (req_phys),
        .req_bus     (req_bus),
        .req_size    (req_size),
        .req_action  (req_action),
        .req_win     (req_win),
        .cur_phys    (cur_phys),
        .cur_bus     (cur_bus),
        .cur_rem     (cur_rem),
        .win_size    (win_size),
        .win_mask    (win_mask),
        .win_ok      (win_ok),
        .wr_valid    (wr_valid),
        .wr_ready    (wr_ready),
        .wr_idx      (wr_idx),
        .wr_enable   (wr_enable),
        .wr_match    (wr_match),
        .wr_remap    (wr_remap),
        .wr_mask     (wr_mask),
        .wr_action   (wr_action),
        .done        (done),
        .done_status (done_status),
        .done_next   (done_next)
    );
endmodule

// File: tb/region_splitter_bench.sv
`timescale 1ns/1ps
module region_splitter_bench;
    localparam int AW = 40;
    localparam int NW = 8;

    typedef struct packed {
        logic          op;
        logic [AW-1:0] phys;
        logic [AW-1:0] bus;
        logic [AW-1:0] size;
        logic [3:0]    win;
        logic [1:0]    st;
        logic [3:0]    cnt;
        logic [3:0]    nxt;
    } row_t;

    localparam int NROWS = 16;
    localparam row_t TBL [NROWS] = '{
        '{1'b0, 40'h0,          40'h0,          40'h10_0000,    4'd0, 2'd0, 4'd1, 4'd1},
        '{1'b0, 40'h3_0000,     40'h103_0000,   40'h5_0000,     4'd1, 2'd0, 4'd2, 4'd3},
        '{1'b0, 40'h5_0000,     40'h5_0000,     40'h0,          4'd3, 2'd0, 4'd0, 4'd3},
        '{1'b1, 40'h0,          40'h0,          40'h0,          4'd3, 2'd0, 4'd5, 4'd8},
        '{1'b0, 40'h10_0000,    40'h18_0000,    40'h10_0000,    4'd0, 2'd1, 4'd0, 4'd0},
        '{1'b0, 40'h0,          40'h0,          40'h1_0000,     4'd0, 2'd2, 4'd0, 4'd0},
        '{1'b1, 40'h0,          40'h0,          40'h0,          4'd5, 2'd1, 4'd8, 4'd8},
        '{1'b0, 40'h8000,       40'h8000,       40'h8000,       4'd0, 2'd1, 4'd0, 4'd0},
        '{1'b1, 40'h0,          40'h0,          40'h0,          4'd0, 2'd1, 4'd8, 4'd8},
        '{1'b0, 40'h1_0000,     40'h1_0000,     40'h7_0000,     4'd6, 2'd1, 4'd2, 4'd8},
        '{1'b1, 40'h0,          40'h0,          40'h0,          4'd8, 2'd1, 4'd8, 4'd8},
        '{1'b0, 40'h1_0000,     40'h1_0000,     40'h3_0000,     4'd6, 2'd0, 4'd2, 4'd8},
        '{1'b1, 40'h0,          40'h0,          40'h0,          4'd8, 2'd0, 4'd0, 4'd8},
        '{1'b0, 40'h1_0000,     40'h2_0000,     40'h1_0000,     4'd0, 2'd0, 4'd1, 4'd1},
        '{1'b0, 40'h80_0000_0000, 40'h0,        40'h80_0000_0000, 4'd1, 2'd0, 4'd1, 4'd2},
        '{1'b1, 40'h0,          40'h0,          40'h0,          4'd2, 2'd0, 4'd6, 4'd8}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic          req_op = 1'b0;
    logic [AW-1:0] req_phys = '0;
    logic [AW-1:0] req_bus = '0;
    logic [AW-1:0] req_size = '0;
    logic [31:0]   req_action = '0;
    logic [3:0]    req_win = '0;
    logic          wr_valid;
    logic          wr_ready = 1'b1;
    logic [2:0]    wr_idx;
    logic          wr_enable;
    logic [AW-1:0] wr_match, wr_remap, wr_mask;
    logic [31:0]   wr_action;
    logic          done;
    logic [1:0]    done_status;
    logic [3:0]    done_next;

    int tests = 0;
    int fails = 0;

    always #2 clk = ~clk;

    region_splitter u_region_splitter (
        .clk (clk), .rst_n (rst_n),
        .req_valid (req_valid), .req_ready (req_ready), .req_op (req_op),
        .req_phys (req_phys), .req_bus (req_bus), .req_size (req_size),
        .req_action (req_action), .req_win (req_win),
        .wr_valid (wr_valid), .wr_ready (wr_ready), .wr_idx (wr_idx),
        .wr_enable (wr_enable), .wr_match (wr_match), .wr_remap (wr_remap),
        .wr_mask (wr_mask), .wr_action (wr_action),
        .done (done), .done_status (done_status), .done_next (done_next)
    );

    task automatic chk(input string req, input string what,
                       input logic [159:0] act, input logic [159:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [AW-1:0] exp_win(input logic [AW-1:0] p, input logic [AW-1:0] r);
        logic [AW-1:0] top;
        logic [AW-1:0] low;
        top = '0;
        for (int i = 0; i < AW; i++) if (r[i]) top = 40'd1 << i;
        low = p & (~p + 40'd1);
        if (p != '0 && low < top) return low;
        return top;
    endfunction

    function automatic string tag_of(input int r);
        case (r)
            2: return "R6";
            4, 7: return "R4";
            5: return "R7";
            9, 11: return "R5";
            3, 6, 8, 10, 12, 15: return "R8";
            default: return "R2";
        endcase
    endfunction

    // Runs one request; stall=1 toggles wr_ready.
    task automatic run_req(input row_t r, input logic [31:0] act, input string tag, input bit stall);
        logic [AW-1:0]  mphys, mbus, mrem, sz;
        int             midx, wcount, k;
        bit             have_prev;
        logic [159:0]   prev;
        int             exp_cyc;
        mphys = r.phys; mbus = r.bus; mrem = r.size;
        midx = r.op ? (NW - int'(r.cnt)) : int'(r.win);
        wcount = 0; have_prev = 0; prev = '0;
        @(negedge clk);
        req_valid = 1'b1; req_op = r.op; req_phys = r.phys; req_bus = r.bus;
        req_size = r.size; req_action = act; req_win = r.win;
        @(negedge clk);
        req_valid = 1'b0;
        k = 1;
        chk("R10", "req_ready low while busy", {159'd0, req_ready}, 160'd0);
        forever begin
            if (stall) wr_ready = k[0];
            if (have_prev) begin
                chk("R9", "payload held in stall",
                    {wr_valid, wr_idx, wr_match, wr_remap, wr_mask, wr_action[28:0]}, prev);
            end
            have_prev = 0;
            if (wr_valid && !wr_ready) begin
                have_prev = 1;
                prev = {1'b1, wr_idx, wr_match, wr_remap, wr_mask, wr_action[28:0]};
            end
            if (wr_valid && wr_ready) begin
                if (r.op) begin
                    chk("R8", "cleared window",
                        {wr_idx, wr_enable, wr_match, wr_remap, wr_mask, wr_action},
                        {3'(midx), 1'b0, 40'd0, 40'd0, 40'd0, 32'd0});
                end else begin
                    sz = exp_win(mphys, mrem);
                    chk("R2", "window payload",
                        {wr_enable, wr_match, wr_remap, wr_mask, wr_action},
                        {1'b1, mphys, mbus, ~(sz - 40'd1), act});
                    chk("R3", "window index", {157'd0, wr_idx}, {157'd0, 3'(midx)});
                    mphys = mphys + sz; mbus = mbus + sz; mrem = mrem - sz;
                end
                midx++;
                wcount++;
            end
            if (done) break;
            if (k > 40) begin
                chk(tag, "done never seen", 160'd0, 160'd1);
                break;
            end
            @(negedge clk);
            k++;
        end
        wr_ready = 1'b1;
        chk(tag, "status", {158'd0, done_status}, {158'd0, r.st});
        chk(tag, "next index", {156'd0, done_next}, {156'd0, r.nxt});
        chk(tag, "write count", 160'(wcount), 160'(r.cnt));
        if (!stall) begin
            exp_cyc = (!r.op && r.st == 2'd2) ? 1 : int'(r.cnt) + 2;
            chk("R9", "cycles to done", 160'(k), 160'(exp_cyc));
        end
        @(negedge clk);
        chk("R10", "done one cycle", {158'd0, done, req_ready}, {158'd0, 1'b0, 1'b1});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual running expected finished");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        row_t sr;
        repeat (3) @(negedge clk);
        chk("R1", "in reset", {157'd0, req_ready, wr_valid, done}, {157'd0, 3'b100});
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "after reset", {157'd0, req_ready, wr_valid, done}, {157'd0, 3'b100});

        for (int i = 0; i < NROWS; i++) begin
            run_req(TBL[i], 32'hA500_0000 + 32'(i), tag_of(i), 1'b0);
        end

        // Stalled write interface (R9)
        sr = '{1'b0, 40'h3_0000, 40'h3_0000, 40'h5_0000, 4'd0, 2'd0, 4'd2, 4'd2};
        run_req(sr, 32'h0000_5A5A, "R9", 1'b1);
        sr = '{1'b1, 40'h0, 40'h0, 40'h0, 4'd2, 2'd0, 4'd6, 4'd8};
        run_req(sr, 32'h0, "R8", 1'b1);

        // Map with index already at the end and size left (R5)
        sr = '{1'b0, 40'h1_0000, 40'h1_0000, 40'h1_0000, 4'd8, 2'd1, 4'd0, 4'd8};
        run_req(sr, 32'h1, "R5", 1'b0);
        sr = '{1'b1, 40'h0, 40'h0, 40'h0, 4'd8, 2'd1, 4'd8, 4'd8};
        run_req(sr, 32'h0, "R8", 1'b0);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule